// File: doc/BRIEF.md
# CPU Error Status Register with Kernel Stack Limit Check

This block collects the error causes a 16-bit minicomputer core reports and holds them in one word-wide status register that software can read and clear. The core sends single-cycle strobes for a halt executed outside kernel mode, for non-existent-memory aborts, for MMU aborts and for external bus timeouts. The block also inspects the address and attributes of every bus access itself. It finds odd word addresses and accesses to an unassigned hole at the bottom of the I/O page, where no device answers.

Every kernel-mode stack push is graded against two limits. A push into the yellow zone lets the write complete and requests a trap. A push into the red zone requests an abort. A push that any other abort hits is escalated to red, so the register holds the red bit together with the bit of the original cause. The block answers each cycle with registered trap and abort pulses and a halt-stop pulse for a legitimate kernel halt. Vector fetch, frame building and the MMU stay in the core.

Top module: `cpuerr_unit`

## Requirements
- R1: After reset the register reads 0 and trap_pulse, abort_pulse and halt_stop are low.
- R2: A cycle with reg_wr high and no new cause clears the register to 0 in the next cycle, whatever it held (a single bit or many bits).
- R3: Cause bits are sticky. A new cause ORs into the held value. When a write and a new cause fall in the same cycle, the register afterwards holds only the new cause.
- R4: halt_exec with cur_mode supervisor (01) or user (11) sets bit value octal 000200 and pulses abort_pulse. With cur_mode kernel (00) it sets no bit and pulses halt_stop instead.
- R5: A valid access with acc_addr bit 0 set sets octal 000100 and aborts.
- R6: nxm_abt sets octal 000040 and aborts.
- R7: A valid access to octal 160000 through 160003, or a bus_tmo strobe, sets octal 000020 and aborts. An access to 160004 raises nothing.
- R8: A kernel push (acc_vld, acc_push, cur_mode 00) writing an address from octal 340 to 377, for example 376, sets octal 000010 and pulses trap_pulse without abort. A write to 400 raises nothing.
- R9: A kernel push writing below octal 340, for example 336, sets octal 000004 and aborts. The same push in user or supervisor mode raises nothing.
- R10: An abort on a kernel push is escalated by also setting octal 000004. An odd address gives 000104, a timeout gives 000024 and a non-existent-memory abort gives 000044. An MMU abort on a kernel push gives 000104, and an MMU abort on any other cycle sets no bit and does not abort.
- R11: The trap, abort and halt-stop pulses and the register value all change one clock after the cycle of the cause. The pulses last one cycle. An abort in the same cycle as a yellow-zone push suppresses both the trap and the yellow bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_mode | input | 2 | Current processor mode: 00 kernel, 01 supervisor, 11 user |
| halt_exec | input | 1 | Strobe: a halt instruction is executed |
| acc_vld | input | 1 | A bus access is issued this cycle |
| acc_push | input | 1 | The access is a stack push write |
| acc_addr | input | 16 | Byte address of the access |
| nxm_abt | input | 1 | Strobe: non-existent-memory abort |
| mmu_abt | input | 1 | Strobe: MMU abort |
| bus_tmo | input | 1 | Strobe: bus timeout reported from outside |
| reg_wr | input | 1 | Write strobe to the register; the written data is irrelevant |
| reg_rdata | output | 16 | Register contents |
| trap_pulse | output | 1 | Request a trap (yellow stack) |
| abort_pulse | output | 1 | Request an abort |
| halt_stop | output | 1 | A kernel-mode halt may stop the machine |

## Verification
The bench builds the block with its default parameters. These are a red limit of octal 340, a yellow limit of octal 400, and a four-byte unanswered hole at octal 160000. These values bring the exact boundary addresses 336, 340, 376, 377 and 400 within reach, along with the hole edges 160000, 160002 and 160004. Each limit is exercised from both sides, and in kernel and non-kernel modes. Escalation is covered for every abort source on a push. The yellow push that is also odd checks abort-over-trap priority.

// File: rtl/cpuerr_pkg.sv
package cpuerr_pkg;

    typedef enum logic [1:0] {
        MODE_KERN = 2'b00,
        MODE_SUPV = 2'b01,
        MODE_RSVD = 2'b10,
        MODE_USER = 2'b11
    } cpu_mode_e;

    typedef enum logic [1:0] {
        ZONE_OK  = 2'd0,
        ZONE_YEL = 2'd1,
        ZONE_RED = 2'd2
    } zone_e;

    // order matches register bits 7 down to 2
    typedef struct packed {
        logic halt;
        logic odd;
        logic nxm;
        logic tmo;
        logic yel;
        logic red;
    } cause_t;

    localparam int CAUSE_W  = $bits(cause_t);
    localparam int CAUSE_LO = 2;
    localparam int BIT_ODD  = CAUSE_LO + 4;
    localparam int BIT_YEL  = CAUSE_LO + 1;
    localparam int BIT_RED  = CAUSE_LO;

endpackage

// File: rtl/cpuerr_zone.sv
module cpuerr_zone
    import cpuerr_pkg::*;
#(
    parameter int              ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] RED_LIM = 16'o000340,
    parameter logic [ADDR_W-1:0] YEL_LIM = 16'o000400
) (
    input  logic              kpush,
    input  logic [ADDR_W-1:0] addr,
    output zone_e             zone
);

    always_comb begin
        zone = ZONE_OK;
        if (kpush) begin
            if (addr < RED_LIM) begin
                zone = ZONE_RED;
            end else if (addr < YEL_LIM) begin
                zone = ZONE_YEL;
            end
        end
    end

endmodule

// File: rtl/cpuerr_hole.sv
module cpuerr_hole #(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] HOLE_BASE  = 16'o160000,
    parameter int                HOLE_BYTES = 4
) (
    input  logic              vld,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam logic [ADDR_W:0] HOLE_END = {1'b0, HOLE_BASE} + (ADDR_W+1)'(HOLE_BYTES);

    generate
        if (HOLE_BYTES > 0) begin : g_hole
            always_comb begin
                hit = vld && (addr >= HOLE_BASE) && ({1'b0, addr} < HOLE_END);
            end
        end else begin : g_nohole
            always_comb begin
                hit = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/cpuerr_cause.sv
module cpuerr_cause
    import cpuerr_pkg::*;
(
    input  cpu_mode_e cur_mode,
    input  logic      halt_exec,
    input  logic      acc_vld,
    input  logic      acc_odd,
    input  logic      kpush,
    input  logic      hole_hit,
    input  zone_e     zone,
    input  logic      nxm_abt,
    input  logic      mmu_abt,
    input  logic      bus_tmo,
    output cause_t    cause,
    output logic      abort,
    output logic      trap,
    output logic      stop
);

    logic halt_bad;
    logic odd_err;
    logic tmo_err;
    logic mmu_push;
    logic fault;
    logic red_err;

    always_comb begin
        halt_bad = halt_exec && (cur_mode != MODE_KERN);
        odd_err  = acc_vld && acc_odd;
        tmo_err  = hole_hit || bus_tmo;
        mmu_push = mmu_abt && kpush;
        fault    = odd_err || tmo_err || nxm_abt || mmu_push;
        red_err  = (zone == ZONE_RED) || (kpush && fault);
        abort    = halt_bad || fault || red_err;

        cause.halt = halt_bad;
        cause.odd  = odd_err || mmu_push;
        cause.nxm  = nxm_abt;
        cause.tmo  = tmo_err;
        cause.red  = red_err;
        cause.yel  = (zone == ZONE_YEL) && !abort;

        trap = cause.yel;
        stop = halt_exec && (cur_mode == MODE_KERN);
    end

endmodule

// File: rtl/cpuerr_regs.sv
module cpuerr_regs
    import cpuerr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   reg_wr,
    input  cause_t cause,
    input  logic   abort,
    input  logic   trap,
    input  logic   stop,
    output cause_t err,
    output logic   abort_pulse,
    output logic   trap_pulse,
    output logic   halt_stop
);

    typedef struct packed {
        cause_t err;
        logic   abort;
        logic   trap;
        logic   stop;
    } state_t;

    state_t state_d;
    state_t state_q;

    always_comb begin
        state_d       = state_q;
        state_d.err   = (reg_wr ? '0 : state_q.err) | cause;
        state_d.abort = abort;
        state_d.trap  = trap;
        state_d.stop  = stop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign err         = state_q.err;
    assign abort_pulse = state_q.abort;
    assign trap_pulse  = state_q.trap;
    assign halt_stop   = state_q.stop;

    // write with no new cause leaves an empty register
    p_write_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (cause == '0)) |=> (state_q.err == '0));

    // without a write no held bit is lost
    p_sticky_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((state_q.err & $past(state_q.err)) == $past(state_q.err)));

    // abort and trap never requested together
    p_abort_over_trap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q.abort && state_q.trap));

endmodule

// File: rtl/cpuerr_unit.sv
module cpuerr_unit
    import cpuerr_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 16,
    parameter logic [ADDR_W-1:0] RED_LIM    = 16'o000340,
    parameter logic [ADDR_W-1:0] YEL_LIM    = 16'o000400,
    parameter logic [ADDR_W-1:0] HOLE_BASE  = 16'o160000,
    parameter int                HOLE_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cur_mode,
    input  logic              halt_exec,
    input  logic              acc_vld,
    input  logic              acc_push,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              nxm_abt,
    input  logic              mmu_abt,
    input  logic              bus_tmo,
    input  logic              reg_wr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              trap_pulse,
    output logic              abort_pulse,
    output logic              halt_stop
);

    localparam int PAD_HI = DATA_W - CAUSE_W - CAUSE_LO;

    cpu_mode_e mode;
    logic      kpush;
    logic      hole_hit;
    zone_e     zone;
    cause_t    cause;
    logic      abort_c;
    logic      trap_c;
    logic      stop_c;
    cause_t    err;

    always_comb begin
        mode  = cpu_mode_e'(cur_mode);
        kpush = acc_vld && acc_push && (mode == MODE_KERN);
    end

    cpuerr_zone #(
        .ADDR_W  (ADDR_W),
        .RED_LIM (RED_LIM),
        .YEL_LIM (YEL_LIM)
    ) u_zone (
        .kpush (kpush),
        .addr  (acc_addr),
        .zone  (zone)
    );

    cpuerr_hole #(
        .ADDR_W     (ADDR_W),
        .HOLE_BASE  (HOLE_BASE),
        .HOLE_BYTES (HOLE_BYTES)
    ) u_hole (
        .vld  (acc_vld),
        .addr (acc_addr),
        .hit  (hole_hit)
    );

    cpuerr_cause u_cause (
        .cur_mode  (mode),
        .halt_exec (halt_exec),
        .acc_vld   (acc_vld),
        .acc_odd   (acc_addr[0]),
        .kpush     (kpush),
        .hole_hit  (hole_hit),
        .zone      (zone),
        .nxm_abt   (nxm_abt),
        .mmu_abt   (mmu_abt),
        .bus_tmo   (bus_tmo),
        .cause     (cause),
        .abort     (abort_c),
        .trap      (trap_c),
        .stop      (stop_c)
    );

    cpuerr_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .cause       (cause),
        .abort       (abort_c),
        .trap        (trap_c),
        .stop        (stop_c),
        .err         (err),
        .abort_pulse (abort_pulse),
        .trap_pulse  (trap_pulse),
        .halt_stop   (halt_stop)
    );

    assign reg_rdata = {{PAD_HI{1'b0}}, err, {CAUSE_LO{1'b0}}};

    // kernel push below the red limit aborts with the red bit
    p_red_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_push && (cur_mode == 2'b00) && (acc_addr < RED_LIM))
        |=> (abort_pulse && reg_rdata[BIT_RED]));

    // odd kernel push is escalated
    p_odd_push_escalates_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_push && (cur_mode == 2'b00) && acc_addr[0])
        |=> (abort_pulse && reg_rdata[BIT_RED] && reg_rdata[BIT_ODD] && !trap_pulse));

    // a kernel halt is allowed to stop the machine
    p_kernel_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_exec && (cur_mode == 2'b00)) |=> halt_stop);

    // a trap is only ever raised by a yellow-zone push
    p_trap_needs_yellow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> ($past(acc_vld && acc_push) && reg_rdata[BIT_YEL]));

endmodule

// File: tb/cpuerr_unit_test.sv
module cpuerr_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic [15:0] rv;
        logic        t;
        logic        a;
        logic        h;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_mode = 2'b00;
    logic        halt_exec = 1'b0;
    logic        acc_vld = 1'b0;
    logic        acc_push = 1'b0;
    logic [15:0] acc_addr = 16'h0;
    logic        nxm_abt = 1'b0;
    logic        mmu_abt = 1'b0;
    logic        bus_tmo = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_rdata;
    logic        trap_pulse;
    logic        abort_pulse;
    logic        halt_stop;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    localparam logic [1:0] K = 2'b00;
    localparam logic [1:0] S = 2'b01;
    localparam logic [1:0] U = 2'b11;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpuerr_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_mode    (cur_mode),
        .halt_exec   (halt_exec),
        .acc_vld     (acc_vld),
        .acc_push    (acc_push),
        .acc_addr    (acc_addr),
        .nxm_abt     (nxm_abt),
        .mmu_abt     (mmu_abt),
        .bus_tmo     (bus_tmo),
        .reg_wr      (reg_wr),
        .reg_rdata   (reg_rdata),
        .trap_pulse  (trap_pulse),
        .abort_pulse (abort_pulse),
        .halt_stop   (halt_stop)
    );

    // driver: one cycle of stimulus plus its expected outcome
    task automatic step(input logic [1:0] mode, input logic halt, input logic vld,
                        input logic push, input logic [15:0] addr, input logic nxm,
                        input logic mmu, input logic tmo, input logic wr,
                        input logic [15:0] er, input logic et, input logic ea,
                        input logic eh, input string tag);
        exp_t e;
        @(negedge clk);
        cur_mode  = mode;
        halt_exec = halt;
        acc_vld   = vld;
        acc_push  = push;
        acc_addr  = addr;
        nxm_abt   = nxm;
        mmu_abt   = mmu;
        bus_tmo   = tmo;
        reg_wr    = wr;
        e.rv = er; e.t = et; e.a = ea; e.h = eh; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input logic [15:0] er, input string tag);
        step(K, 0, 0, 0, 16'h0, 0, 0, 0, 0, er, 0, 0, 0, tag);
    endtask

    task automatic clr(input string tag);
        step(K, 0, 0, 0, 16'h0, 0, 0, 0, 1, 16'h0, 0, 0, 0, tag);
    endtask

    task automatic acc(input logic [1:0] mode, input logic push, input logic [15:0] addr,
                       input logic [15:0] er, input logic et, input logic ea, input string tag);
        step(mode, 0, 1, push, addr, 0, 0, 0, 0, er, et, ea, 0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // monitor: compare outputs a quarter period after each rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q.size() != 0) begin
                e = q.pop_front();
                checks++;
                if (reg_rdata !== e.rv || trap_pulse !== e.t ||
                    abort_pulse !== e.a || halt_stop !== e.h) begin
                    fails++;
                    $display("FAIL %s: got reg=%06o trap=%b abort=%b stop=%b, expected reg=%06o trap=%b abort=%b stop=%b",
                             e.tag, reg_rdata, trap_pulse, abort_pulse, halt_stop,
                             e.rv, e.t, e.a, e.h);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion within %0d cycles", WATCHDOG);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        idle(16'o0, "R1 reset state");
        idle(16'o0, "R1 idle after reset");

        // odd address
        acc(U, 0, 16'o000001, 16'o000100, 0, 1, "R5 odd access");
        idle(16'o000100, "R11 pulse lasts one cycle, bit held");
        clr("R2 clear after odd");

        // halt
        step(U, 1, 0, 0, 16'h0, 0, 0, 0, 0, 16'o000200, 0, 1, 0, "R4 halt user");
        clr("R2 clear after halt");
        step(S, 1, 0, 0, 16'h0, 0, 0, 0, 0, 16'o000200, 0, 1, 0, "R4 halt supervisor");
        clr("R2 clear after halt sup");
        step(K, 1, 0, 0, 16'h0, 0, 0, 0, 0, 16'o0, 0, 0, 1, "R4 halt kernel stops");
        idle(16'o0, "R11 halt_stop single cycle");

        // nxm and sticky
        step(K, 0, 0, 0, 16'h0, 1, 0, 0, 0, 16'o000040, 0, 1, 0, "R6 nxm");
        acc(K, 0, 16'o001001, 16'o000140, 0, 1, "R3 sticky OR");
        step(K, 0, 0, 0, 16'h0, 1, 0, 0, 1, 16'o000040, 0, 1, 0, "R3 write with new cause");
        clr("R2 clear multi");

        // timeout
        acc(K, 0, 16'o160000, 16'o000020, 0, 1, "R7 hole base");
        clr("R2 clear");
        step(U, 0, 0, 0, 16'h0, 0, 0, 1, 0, 16'o000020, 0, 1, 0, "R7 external timeout");
        clr("R2 clear");
        acc(K, 0, 16'o160002, 16'o000020, 0, 1, "R7 hole upper word");
        clr("R2 clear");
        acc(K, 0, 16'o160004, 16'o0, 0, 0, "R7 past hole no error");

        // yellow
        acc(K, 1, 16'o000376, 16'o000010, 1, 0, "R8 yellow 376");
        idle(16'o000010, "R11 trap single cycle");
        clr("R2 clear");
        acc(K, 1, 16'o000340, 16'o000010, 1, 0, "R8 yellow lower edge 340");
        clr("R2 clear");
        acc(K, 1, 16'o000400, 16'o0, 0, 0, "R8 push at 400 fine");

        // red
        acc(K, 1, 16'o000336, 16'o000004, 0, 1, "R9 red 336");
        clr("R2 clear");
        acc(U, 1, 16'o000336, 16'o0, 0, 0, "R9 user push ignored");
        acc(S, 1, 16'o000376, 16'o0, 0, 0, "R9 supervisor yellow ignored");

        // escalation
        acc(K, 1, 16'o000777, 16'o000104, 0, 1, "R10 odd push");
        clr("R2 clear");
        acc(K, 1, 16'o160002, 16'o000024, 0, 1, "R10 timeout push");
        clr("R2 clear");
        step(K, 0, 1, 1, 16'o001000, 1, 0, 0, 0, 16'o000044, 0, 1, 0, "R10 nxm push");
        clr("R2 clear");
        step(K, 0, 1, 1, 16'o001000, 0, 1, 0, 0, 16'o000104, 0, 1, 0, "R10 mmu push");
        clr("R2 clear");
        step(K, 0, 1, 0, 16'o001000, 0, 1, 0, 0, 16'o0, 0, 0, 0, "R10 mmu non-push no effect");

        // priority
        acc(K, 1, 16'o000377, 16'o000104, 0, 1, "R11 odd yellow push aborts only");
        clr("R2 clear");
        step(K, 0, 1, 1, 16'o000376, 1, 0, 0, 0, 16'o000044, 0, 1, 0, "R11 nxm on yellow push");
        clr("R2 final clear");
        idle(16'o0, "R2 stays clear");

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: got %0d pending items, expected 0", q.size());
        end
        finish_run();
    end

endmodule